// File: doc/BRIEF.md
# Clock Bank Gating and Frequency Profile Control

This block sits between the synthesis core of an eight-output clock generator and its pins. The eight outputs form four banks of two, and each bank has one incoming synthesized clock. Five raw control pins each take one role from a static map: a global enable, the enable of one bank, frequency-select bit 0, frequency-select bit 1, reset, or no role. Every pin is resynchronized into the system clock domain. The decoded enables then gate the bank clocks so that no output pulse is ever cut short.

The block also holds the active frequency profile. It reloads the profile from the select pins only after a reset pulse that is long enough, or after power-on reset. From the moment the reset qualifies until the new profile is in force, it forces every output low and raises a squelch flag. A reserved select code leaves the old profile in place and sets a sticky error flag. A parameter chooses between a three-profile decode and a two-profile decode.

Top module: `clkctl_pin_ctrl`

## Requirements
- R1: A running bank b copies its bank clock onto outputs 2b and 2b+1. Bank index 0 through 3 maps to output pairs 0/1, 2/3, 4/5 and 6/7.
- R2: Enables are active low. A bank runs only when its own enable pin and the global enable pin are both low. A role that no pin carries counts as low.
- R3: A stopped bank holds both of its outputs at a steady 0.
- R4: Starting or stopping a bank never produces a high pulse different from the bank clock's high time. It never produces a low pulse shorter than the bank clock's low time.
- R5: In three-profile mode the code {bit1,bit0} loads profile_o as 01 gives 1, 10 gives 2 and 11 gives 3.
- R6: In three-profile mode a latched code 00 keeps the previous profile and sets cfg_err_o. cfg_err_o then stays high until rst_n.
- R7: In two-profile mode only bit 1 counts: 0 gives profile 1 and 1 gives profile 2. No code sets cfg_err_o.
- R8: Changing the select pins has no effect unless the reset pin stays high for at least RST_MIN_CYC system cycles. A pulse of RST_MIN_CYC-1 cycles leaves the profile unchanged and never raises squelch_o. A pulse of exactly RST_MIN_CYC cycles is accepted.
- R9: Once a reset pulse qualifies, squelch_o stays high until the new profile loads, and all outputs go to 0. A bank stops within GATE_STAGES falling edges of its own clock.
- R10: While rst_n is low, all outputs are 0, squelch_o is 1, profile_o is 1 and cfg_err_o is 0. After release, squelch_o stays high for SETTLE_CYC cycles, then the profile loads from the pins and squelch_o falls.
- R11: A select-bit-0 role is honoured only on pin index 1 (P2) and a select-bit-1 role only on pin index 2 (P3). A reset role is honoured on any pin except index 1. A role placed anywhere else is treated as no role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for synchronizers, reset timing and profile logic |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl_pins_i | input | NUM_PINS (5) | Raw control pins P1..P5 at indices 0..4 |
| bank_clk_i | input | NUM_BANKS (4) | Synthesized clock of each bank |
| clk_out_o | output | NUM_BANKS*OUTS_PER_BANK (8) | Gated output clocks |
| profile_o | output | 2 | Active profile number, 1 to 3 |
| squelch_o | output | 1 | High while outputs are forced low for a profile change |
| cfg_err_o | output | 1 | Sticky flag: reserved select code was latched |

## Verification
Two functions can collide here: an enable pin may change in the same system cycle that a reset pulse qualifies. Squelch and enable gating then both act on the same bank-clock resynchronizer. The bench raises the bank A enable on exactly the cycle the reset count reaches its minimum. It then checks that every output stays low through the hold, and that after the new profile loads only banks B to D run. Edge monitors watch every bank throughout, and any high pulse or low gap that differs from the bank clock's half period counts against R4.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

  localparam int ROLE_W = 4;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_NONE      = 4'd0,
    ROLE_OE_ALL    = 4'd1,
    ROLE_OE_BANK0  = 4'd2,
    ROLE_OE_BANK1  = 4'd3,
    ROLE_OE_BANK2  = 4'd4,
    ROLE_OE_BANK3  = 4'd5,
    ROLE_FSEL0     = 4'd6,
    ROLE_FSEL1     = 4'd7,
    ROLE_RESET     = 4'd8
  } pin_role_e;

  // Pin indices whose role choice is restricted
  localparam int FSEL0_PIN       = 1;
  localparam int FSEL1_PIN       = 2;
  localparam int RESET_BANNED    = 1;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_HOLD   = 2'd1,
    PS_SETTLE = 2'd2
  } prof_state_e;

  localparam logic [1:0] PROFILE_DEFAULT = 2'd1;

  // Whether a role may be honoured on a given pin index
  function automatic logic role_legal(input int pin, input logic [ROLE_W-1:0] role);
    case (role)
      ROLE_FSEL0: return pin == FSEL0_PIN;
      ROLE_FSEL1: return pin == FSEL1_PIN;
      ROLE_RESET: return pin != RESET_BANNED;
      default:    return 1'b1;
    endcase
  endfunction

  // Profile number chosen by a select code; prev is kept on the reserved code
  function automatic logic [1:0] decode_profile(input logic three,
                                                input logic [1:0] code,
                                                input logic [1:0] prev);
    if (!three)           return code[1] ? 2'd2 : 2'd1;
    else if (code == 2'b00) return prev;
    else                  return code;
  endfunction

  function automatic logic code_reserved(input logic three, input logic [1:0] code);
    return three && (code == 2'b00);
  endfunction

endpackage

// File: rtl/clkctl_sync.sv
`timescale 1ns/1ps
module clkctl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/clkctl_role_decode.sv
`timescale 1ns/1ps
module clkctl_role_decode import clkctl_pkg::*; #(
  parameter int NUM_PINS  = 5,
  parameter int NUM_BANKS = 4,
  parameter logic [NUM_PINS*ROLE_W-1:0] PIN_ROLE_MAP = '0
) (
  input  logic [NUM_PINS-1:0]  pins_s_i,
  output logic [NUM_BANKS-1:0] bank_run_o,
  output logic [1:0]           fsel_o,
  output logic                 rst_lvl_o
);
  logic                 all_off;
  logic [NUM_BANKS-1:0] bank_off;

  always_comb begin
    all_off   = 1'b0;
    bank_off  = '0;
    fsel_o    = '0;
    rst_lvl_o = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (role_legal(i, PIN_ROLE_MAP[i*ROLE_W +: ROLE_W])) begin
        if (PIN_ROLE_MAP[i*ROLE_W +: ROLE_W] == ROLE_OE_ALL) all_off   = all_off | pins_s_i[i];
        if (PIN_ROLE_MAP[i*ROLE_W +: ROLE_W] == ROLE_FSEL0)  fsel_o[0] = pins_s_i[i];
        if (PIN_ROLE_MAP[i*ROLE_W +: ROLE_W] == ROLE_FSEL1)  fsel_o[1] = pins_s_i[i];
        if (PIN_ROLE_MAP[i*ROLE_W +: ROLE_W] == ROLE_RESET)  rst_lvl_o = rst_lvl_o | pins_s_i[i];
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (PIN_ROLE_MAP[i*ROLE_W +: ROLE_W] == ROLE_W'(int'(ROLE_OE_BANK0) + b))
            bank_off[b] = bank_off[b] | pins_s_i[i];
        end
      end
    end
  end

  assign bank_run_o = ~bank_off & {NUM_BANKS{~all_off}};
endmodule

// File: rtl/clkctl_profile.sv
`timescale 1ns/1ps
module clkctl_profile import clkctl_pkg::*; #(
  parameter int RST_MIN_CYC    = 40,
  parameter int SETTLE_CYC     = 16,
  parameter int THREE_PROFILES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_lvl_i,
  input  logic [1:0] fsel_i,
  output logic       squelch_o,
  output logic [1:0] profile_o,
  output logic       cfg_err_o,
  output logic       rst_qualified_o,
  output logic       latch_evt_o
);
  localparam int HW = $clog2(RST_MIN_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [HW-1:0] HI_MAX      = HW'(RST_MIN_CYC);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
  localparam logic          THREE       = (THREE_PROFILES != 0);

  logic [HW-1:0] hi_cnt;
  logic [SW-1:0] settle_cnt;
  prof_state_e   state;
  logic [1:0]    profile_q;
  logic          err_q;

  // Length of the current reset-level run, saturating at the minimum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!rst_lvl_i)     hi_cnt <= '0;
    else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
  end

  assign rst_qualified_o = (hi_cnt == HI_MAX);
  assign latch_evt_o     = (state == PS_SETTLE) && !rst_qualified_o && (settle_cnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_SETTLE;
      settle_cnt <= '0;
      profile_q  <= PROFILE_DEFAULT;
      err_q      <= 1'b0;
    end else begin
      case (state)
        PS_RUN: begin
          if (rst_qualified_o) state <= PS_HOLD;
        end
        PS_HOLD: begin
          if (!rst_lvl_i) begin
            state      <= PS_SETTLE;
            settle_cnt <= '0;
          end
        end
        default: begin
          if (rst_qualified_o) begin
            state <= PS_HOLD;
          end else if (latch_evt_o) begin
            state     <= PS_RUN;
            profile_q <= decode_profile(THREE, fsel_i, profile_q);
            if (code_reserved(THREE, fsel_i)) err_q <= 1'b1;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign squelch_o = (state != PS_RUN);
  assign profile_o = profile_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/clkctl_bank_gate.sv
`timescale 1ns/1ps
module clkctl_bank_gate #(
  parameter int GATE_STAGES = 2
) (
  input  logic bank_clk_i,
  input  logic rst_n,
  input  logic run_req_i,
  output logic gclk_o
);
  logic [GATE_STAGES-1:0] en_pipe;

  // Enable moves only on falling edges, while the bank clock is low
  always_ff @(negedge bank_clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_pipe <= '0;
    end else begin
      en_pipe[0] <= run_req_i;
      for (int k = 1; k < GATE_STAGES; k++) en_pipe[k] <= en_pipe[k-1];
    end
  end

  assign gclk_o = bank_clk_i & en_pipe[GATE_STAGES-1];
endmodule

// File: rtl/clkctl_pin_ctrl.sv
`timescale 1ns/1ps
module clkctl_pin_ctrl import clkctl_pkg::*; #(
  parameter int NUM_PINS       = 5,
  parameter int NUM_BANKS      = 4,
  parameter int OUTS_PER_BANK  = 2,
  parameter int SYNC_STAGES    = 2,
  parameter int GATE_STAGES    = 2,
  parameter int RST_MIN_CYC    = 40,
  parameter int SETTLE_CYC     = 16,
  parameter int THREE_PROFILES = 1,
  parameter logic [NUM_PINS*ROLE_W-1:0] PIN_ROLE_MAP = 20'h18762
) (
  input  logic                               sys_clk,
  input  logic                               rst_n,
  input  logic [NUM_PINS-1:0]                ctl_pins_i,
  input  logic [NUM_BANKS-1:0]               bank_clk_i,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_out_o,
  output logic [1:0]                         profile_o,
  output logic                               squelch_o,
  output logic                               cfg_err_o
);
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;

  logic [NUM_PINS-1:0]  pins_s;
  logic [NUM_BANKS-1:0] bank_run;
  logic [NUM_BANKS-1:0] run_req;
  logic [NUM_BANKS-1:0] bank_gclk;
  logic [1:0]           fsel;
  logic                 rst_lvl;
  logic                 rst_qualified;
  logic                 latch_evt;

  clkctl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) pin_sync_i (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .d_i   (ctl_pins_i),
    .q_o   (pins_s)
  );

  clkctl_role_decode #(
    .NUM_PINS     (NUM_PINS),
    .NUM_BANKS    (NUM_BANKS),
    .PIN_ROLE_MAP (PIN_ROLE_MAP)
  ) decode_i (
    .pins_s_i   (pins_s),
    .bank_run_o (bank_run),
    .fsel_o     (fsel),
    .rst_lvl_o  (rst_lvl)
  );

  clkctl_profile #(
    .RST_MIN_CYC    (RST_MIN_CYC),
    .SETTLE_CYC     (SETTLE_CYC),
    .THREE_PROFILES (THREE_PROFILES)
  ) profile_i (
    .clk             (sys_clk),
    .rst_n           (rst_n),
    .rst_lvl_i       (rst_lvl),
    .fsel_i          (fsel),
    .squelch_o       (squelch_o),
    .profile_o       (profile_o),
    .cfg_err_o       (cfg_err_o),
    .rst_qualified_o (rst_qualified),
    .latch_evt_o     (latch_evt)
  );

  assign run_req = bank_run & {NUM_BANKS{~squelch_o}};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkctl_bank_gate #(.GATE_STAGES(GATE_STAGES)) gate_i (
      .bank_clk_i (bank_clk_i[b]),
      .rst_n      (rst_n),
      .run_req_i  (run_req[b]),
      .gclk_o     (bank_gclk[b])
    );
    for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : g_out
      assign clk_out_o[b*OUTS_PER_BANK + o] = bank_gclk[b];
    end
  end

  if (NUM_OUTS < 1) begin : g_bad_cfg
    $error("clkctl_pin_ctrl needs at least one output");
  end
endmodule

// File: rtl/clkctl_pin_ctrl_chk.sv
`timescale 1ns/1ps
module clkctl_pin_ctrl_chk #(
  parameter int NUM_BANKS      = 4,
  parameter int OUTS_PER_BANK  = 2,
  parameter int THREE_PROFILES = 1
) (
  input logic                               sys_clk,
  input logic                               rst_n,
  input logic [NUM_BANKS-1:0]               bank_clk,
  input logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_out,
  input logic [1:0]                         profile,
  input logic                               squelch,
  input logic                               cfg_err,
  input logic                               rst_qualified,
  input logic                               latch_evt
);
  for (genvar o = 0; o < NUM_BANKS*OUTS_PER_BANK; o++) begin : g_out_chk
    // R1
    gate_follows_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      clk_out[o] |-> bank_clk[o / OUTS_PER_BANK]);
  end

  // R5
  profile_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !latch_evt |=> $stable(profile));

  // R5
  profile_nonzero_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    profile != 2'd0);

  // R6
  err_sticky_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R9
  squelch_on_reset_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rst_qualified |=> squelch);

  // R10
  release_after_latch_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    latch_evt |=> !squelch);

  if (THREE_PROFILES == 0) begin : g_two
    // R7
    two_prof_range_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (profile != 2'd3) && !cfg_err);
  end
endmodule

bind clkctl_pin_ctrl clkctl_pin_ctrl_chk #(
  .NUM_BANKS      (NUM_BANKS),
  .OUTS_PER_BANK  (OUTS_PER_BANK),
  .THREE_PROFILES (THREE_PROFILES)
) chk_i (
  .sys_clk       (sys_clk),
  .rst_n         (rst_n),
  .bank_clk      (bank_clk_i),
  .clk_out       (clk_out_o),
  .profile       (profile_o),
  .squelch       (squelch_o),
  .cfg_err       (cfg_err_o),
  .rst_qualified (rst_qualified),
  .latch_evt     (latch_evt)
);

// File: tb/clkctl_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkctl_pin_ctrl_tb_top;
  localparam int RMIN   = 40;
  localparam int SETTLE = 16;
  localparam int WD_CYC = 100000;
  localparam realtime HALF [4] = '{7.0, 9.0, 11.0, 13.0};

  // pin index: 0=P1 bank0 enable, 1=P2 sel bit0, 2=P3 sel bit1, 3=P4 reset, 4=P5 global enable
  typedef struct packed {
    logic [4:0] pins;
    logic [3:0] run;
    logic [1:0] prof;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{5'b00100, 4'b1111, 2'd2},
    '{5'b00101, 4'b1110, 2'd2},
    '{5'b10100, 4'b0000, 2'd2},
    '{5'b10101, 4'b0000, 2'd2},
    '{5'b00110, 4'b1111, 2'd2},
    '{5'b00000, 4'b1111, 2'd2},
    '{5'b00001, 4'b1110, 2'd2}
  };

  logic sys_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic [4:0] pins = 5'b00100;
  logic bclk0 = 1'b0, bclk1 = 1'b0, bclk2 = 1'b0, bclk3 = 1'b0;
  logic [3:0] bclk;
  logic [7:0] clk_out1, clk_out2;
  logic [1:0] prof1, prof2;
  logic sq1, sq2, err1, err2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int sq1_cnt = 0;
  int sq2_cnt = 0;

  always #2.5 sys_clk = ~sys_clk;
  initial begin #0.3; forever #(HALF[0]) bclk0 = ~bclk0; end
  initial begin #0.3; forever #(HALF[1]) bclk1 = ~bclk1; end
  initial begin #0.3; forever #(HALF[2]) bclk2 = ~bclk2; end
  initial begin #0.3; forever #(HALF[3]) bclk3 = ~bclk3; end
  assign bclk = {bclk3, bclk2, bclk1, bclk0};

  clkctl_pin_ctrl #(.RST_MIN_CYC(RMIN), .SETTLE_CYC(SETTLE), .THREE_PROFILES(1),
                    .PIN_ROLE_MAP(20'h18762)) dut_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .ctl_pins_i(pins), .bank_clk_i(bclk),
    .clk_out_o(clk_out1), .profile_o(prof1), .squelch_o(sq1), .cfg_err_o(err1));

  // Second copy: two-profile decode, and a reset role wrongly placed on P2
  clkctl_pin_ctrl #(.RST_MIN_CYC(RMIN), .SETTLE_CYC(SETTLE), .THREE_PROFILES(0),
                    .PIN_ROLE_MAP(20'h18782)) dut2_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .ctl_pins_i(pins), .bank_clk_i(bclk),
    .clk_out_o(clk_out2), .profile_o(prof2), .squelch_o(sq2), .cfg_err_o(err2));

  always @(posedge sys_clk) begin
    if (sq1) sq1_cnt++;
    if (sq2) sq2_cnt++;
  end

  // Pulse-width monitors on the first output of each bank (R4)
  logic [3:0] glitch;
  for (genvar g = 0; g < 4; g++) begin : gmon
    int bad = 0;
    wire og = clk_out1[2*g];
    initial begin
      realtime tr, tf;
      tf = -1.0;
      forever begin
        @(posedge og);
        if (tf >= 0.0 && ($realtime - tf) < HALF[g] - 0.05) bad++;
        tr = $realtime;
        @(negedge og);
        if (($realtime - tr) < HALF[g] - 0.05 || ($realtime - tr) > HALF[g] + 0.05) bad++;
        tf = $realtime;
      end
    end
    assign glitch[g] = (bad != 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_banks(input logic [3:0] exp_run, input string tag);
    int miss [4];
    for (int b = 0; b < 4; b++) miss[b] = 0;
    repeat (60) begin
      @(negedge sys_clk);
      for (int b = 0; b < 4; b++) begin
        logic e;
        e = exp_run[b] ? bclk[b] : 1'b0;
        if (clk_out1[2*b] !== e || clk_out1[2*b+1] !== e) miss[b]++;
      end
    end
    for (int b = 0; b < 4; b++)
      check(miss[b] == 0, exp_run[b] ? "R1/R2" : "R2/R3",
            $sformatf("%s bank %0d sample mismatches", tag, b), miss[b], 0);
  endtask

  task automatic pulse_rst(input int n);
    @(negedge sys_clk) pins[3] = 1'b1;
    repeat (n) @(negedge sys_clk);
    pins[3] = 1'b0;
    repeat (SETTLE + 20) @(negedge sys_clk);
  endtask

  task automatic set_sel(input logic b1, input logic b0);
    @(negedge sys_clk);
    pins[2] = b1;
    pins[1] = b0;
    repeat (5) @(negedge sys_clk);
  endtask

  initial begin
    int s1, s2, low_miss, sq_miss;
    // R10: state during reset, select code 10 on the pins
    repeat (20) @(negedge sys_clk);
    check(clk_out1 == 8'h00, "R10", "outputs in reset", clk_out1, 0);
    check(sq1 == 1'b1, "R10", "squelch in reset", sq1, 1);
    check(prof1 == 2'd1, "R10", "profile in reset", prof1, 1);
    check(err1 == 1'b0, "R10", "error flag in reset", err1, 0);
    rst_n = 1'b1;
    repeat (SETTLE + 10) @(negedge sys_clk);
    check(prof1 == 2'd2, "R10", "profile after power-on latch", prof1, 2);
    check(sq1 == 1'b0, "R10", "squelch after settle", sq1, 0);
    check(prof2 == 2'd2, "R7", "two-profile power-on with bit1=1", prof2, 2);

    // Table of enable patterns; select pins move without any reset (R8)
    foreach (VECS[v]) begin
      @(negedge sys_clk) pins = VECS[v].pins;
      repeat (40) @(negedge sys_clk);
      check_banks(VECS[v].run, $sformatf("vector %0d", v));
      check(prof1 == VECS[v].prof, "R8", $sformatf("vector %0d profile", v), prof1, VECS[v].prof);
    end

    // R8: pulse one cycle short of the minimum, select code 11
    @(negedge sys_clk) pins = 5'b00110;
    repeat (10) @(negedge sys_clk);
    s1 = sq1_cnt;
    pulse_rst(RMIN - 1);
    check(prof1 == 2'd2, "R8", "short pulse leaves profile", prof1, 2);
    check(sq1_cnt == s1, "R8", "short pulse squelch cycles", sq1_cnt - s1, 0);

    // R8 boundary: exactly the minimum is accepted, code 11
    s1 = sq1_cnt;
    pulse_rst(RMIN);
    check(prof1 == 2'd3, "R5", "code 11 after minimum pulse", prof1, 3);
    check(sq1_cnt > s1, "R8", "minimum pulse squelch seen", sq1_cnt - s1, 1);
    check(prof2 == 2'd2, "R7", "two-profile code 11 gives 2", prof2, 2);

    // Collision: bank0 enable rises on the cycle the reset qualifies; code 01
    set_sel(1'b0, 1'b1);
    @(negedge sys_clk) pins[3] = 1'b1;
    repeat (RMIN) @(negedge sys_clk);
    pins[0] = 1'b1;
    repeat (25) @(negedge sys_clk);
    low_miss = 0;
    sq_miss = 0;
    repeat (20) begin
      @(negedge sys_clk);
      if (clk_out1 != 8'h00) low_miss++;
      if (sq1 != 1'b1) sq_miss++;
    end
    check(low_miss == 0, "R9", "outputs during reset hold", low_miss, 0);
    check(sq_miss == 0, "R9", "squelch during reset hold", sq_miss, 0);
    pins[3] = 1'b0;
    repeat (SETTLE + 20) @(negedge sys_clk);
    check(prof1 == 2'd1, "R5", "code 01 gives profile 1", prof1, 1);
    check(sq1 == 1'b0, "R9", "squelch released", sq1, 0);
    check(prof2 == 2'd1, "R7", "two-profile code 01 gives 1", prof2, 1);
    check_banks(4'b1110, "after collision");
    @(negedge sys_clk) pins[0] = 1'b0;

    // R6: reserved code keeps profile and sets the flag
    set_sel(1'b0, 1'b0);
    pulse_rst(RMIN + 5);
    check(prof1 == 2'd1, "R6", "reserved code keeps profile", prof1, 1);
    check(err1 == 1'b1, "R6", "reserved code error flag", err1, 1);
    check(prof2 == 2'd1, "R7", "two-profile code 00 gives 1", prof2, 1);
    check(err2 == 1'b0, "R7", "two-profile no error", err2, 0);

    // R6 sticky through a valid reload, code 10
    set_sel(1'b1, 1'b0);
    pulse_rst(RMIN + 5);
    check(prof1 == 2'd2, "R5", "code 10 gives profile 2", prof1, 2);
    check(err1 == 1'b1, "R6", "error flag sticky", err1, 1);

    // R11: reset role placed on P2 in the second copy must do nothing
    s2 = sq2_cnt;
    s1 = sq1_cnt;
    @(negedge sys_clk) pins[1] = 1'b1;
    repeat (RMIN + 20) @(negedge sys_clk);
    pins[1] = 1'b0;
    repeat (SETTLE + 20) @(negedge sys_clk);
    check(sq2_cnt == s2, "R11", "illegal reset pin squelch cycles", sq2_cnt - s2, 0);
    check(prof2 == 2'd2, "R11", "illegal reset pin profile", prof2, 2);
    check(sq1_cnt == s1, "R8", "select bit toggled without reset", sq1_cnt - s1, 0);

    // R4: no truncated pulse on any bank over the whole run
    for (int b = 0; b < 4; b++)
      check(glitch[b] == 1'b0, "R4", $sformatf("bank %0d pulse width violation", b), glitch[b], 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge sys_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule